// File: doc/BRIEF.md
# Processor Interrupt Pin Controller

This block stands between a processor's external control pins and the core's interrupt logic. Each pin first passes through a two-flop synchroniser. The block then compares the synchronised level with a stored copy of the level it last acted on. A pin does something only when its level has changed. The kind of action depends on the pin: some pins follow a level, one reacts to a falling edge, one latches a halt, one raises a reset request, and one gates the time base.

Every interrupt-type event lands in a 32-bit pending vector. The core reads this vector and clears bits in it through a per-bit acknowledge mask. The summary request `irqReq` is high whenever any pending bit is set. Interrupt vectoring, priority resolution inside the core and the reset sequence itself are handled elsewhere.

Top module: `pin_irq_ctrl`

## Requirements
- R1: A pin acts only when its synchronised level differs from the stored level for that pin. Holding a pin at the same level triggers nothing more, so a pending bit that the core has acknowledged stays clear while the pin is held.
- R2: A pin change driven before clock edge k first shows at the outputs after edge k+2. The synchroniser adds two edges and the output registers add one.
- R3: Pin 0 (external interrupt) and pin 1 (management interrupt) are active-high levels. Each sets its pending bit on a rise and clears it on a fall: pin 0 drives bit 0 and pin 1 drives bit 1.
- R4: Pin 2 (machine check) sets pending bit 2 on a 1-to-0 change. A 0-to-1 change leaves that bit as it is.
- R5: `irqReq` is 1 in exactly those cycles in which the pending vector is non-zero. It updates in the same cycle as the vector.
- R6: A rise on pin 3 (checkstop) sets `haltOut`. A later fall on pin 3 leaves `haltOut` set; only `rst` clears it.
- R7: A rise on pin 4 (hard reset) makes `resetReq` high for exactly one cycle. A fall on pin 4 does nothing.
- R8: Pin 5 (soft reset) is a level that sets pending bit 3 on a rise and clears it on a fall.
- R9: Pin 6 (time base enable) drives `tbEnable` high on a rise and low on a fall. It never changes the pending vector.
- R10: Each 1 in `ackClear` clears the matching pending bit at the next edge. If a pin sets the same bit at that same edge, the set wins.
- R11: Pins with an index of 7 or higher have no effect on any output.
- R12: The synchronous reset `rst` clears the pending vector, `irqReq`, `haltOut`, `resetReq`, `tbEnable`, the synchroniser and the stored levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pinIn | input | PIN_W (8) | Asynchronous pin levels; pin roles are listed in R3 to R11 |
| ackClear | input | PEND_W (32) | Per-bit clear mask for the pending vector |
| pending | output | PEND_W (32) | Pending interrupt vector |
| irqReq | output | 1 | Summary interrupt request to the core |
| haltOut | output | 1 | Sticky halt after a checkstop |
| resetReq | output | 1 | One-cycle system reset request |
| tbEnable | output | 1 | Time base run enable |

## Verification
Pin-driven results are due three edges after the pin is driven, and acknowledge results one edge after `ackClear` is driven. The bench drives every input on the falling clock edge. Its directed checks wait for exactly that number of rising edges and then sample on the following falling edge. One early check samples after only two edges to confirm that nothing has moved yet. In addition, a behavioural model in the bench delays the pin values through two queue stages and compares every output on every falling edge, so a result that arrives a cycle early or late is caught wherever it occurs.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  // pin roles by index
  localparam int PIN_EXT   = 0;
  localparam int PIN_SMI   = 1;
  localparam int PIN_MCK   = 2;
  localparam int PIN_CKSTP = 3;
  localparam int PIN_HRST  = 4;
  localparam int PIN_SRST  = 5;
  localparam int PIN_TBEN  = 6;
  localparam int NUM_KNOWN = 7;

  // pending bit positions decoded by the core
  localparam int PB_EXT = 0;
  localparam int PB_SMI = 1;
  localparam int PB_MCK = 2;
  localparam int PB_RST = 3;

  typedef struct packed {
    logic extSet;
    logic extClr;
    logic smiSet;
    logic smiClr;
    logic mckSet;
    logic rstSet;
    logic rstClr;
    logic haltSet;
    logic sysReset;
    logic tbOn;
    logic tbOff;
  } pin_strobe_t;
endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pinctl_ctrl.sv
module pinctl_ctrl
  import pinctl_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] synced,
  output pin_strobe_t      str
);
  localparam logic [PIN_W-1:0] RECOG_MASK = PIN_W'((64'd1 << NUM_KNOWN) - 64'd1);

  logic [PIN_W-1:0] lastLevel;
  logic [PIN_W-1:0] riseVec;
  logic [PIN_W-1:0] fallVec;

  always_ff @(posedge clk) begin
    if (rst) lastLevel <= '0;
    else     lastLevel <= synced & RECOG_MASK;
  end

  always_comb begin
    riseVec = synced & ~lastLevel & RECOG_MASK;
    fallVec = ~synced & lastLevel & RECOG_MASK;
    str.extSet   = riseVec[PIN_EXT];
    str.extClr   = fallVec[PIN_EXT];
    str.smiSet   = riseVec[PIN_SMI];
    str.smiClr   = fallVec[PIN_SMI];
    str.mckSet   = fallVec[PIN_MCK];
    str.rstSet   = riseVec[PIN_SRST];
    str.rstClr   = fallVec[PIN_SRST];
    str.haltSet  = riseVec[PIN_CKSTP];
    str.sysReset = riseVec[PIN_HRST];
    str.tbOn     = riseVec[PIN_TBEN];
    str.tbOff    = fallVec[PIN_TBEN];
  end

  AST_NO_REPEAT_EVENT: assert property (@(posedge clk) disable iff (rst)
    $stable(synced) |-> (str == '0)); // R1
endmodule

// File: rtl/pinctl_dp.sv
module pinctl_dp
  import pinctl_pkg::*;
#(
  parameter int PEND_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  pin_strobe_t       str,
  input  logic [PEND_W-1:0] ackClear,
  output logic [PEND_W-1:0] pending,
  output logic              irqReq,
  output logic              haltOut,
  output logic              resetReq,
  output logic              tbEnable
);
  logic [PEND_W-1:0] setVec;
  logic [PEND_W-1:0] clrVec;
  logic [PEND_W-1:0] pendNext;

  always_comb begin
    setVec = '0;
    clrVec = '0;
    setVec[PB_EXT] = str.extSet;
    clrVec[PB_EXT] = str.extClr;
    setVec[PB_SMI] = str.smiSet;
    clrVec[PB_SMI] = str.smiClr;
    setVec[PB_MCK] = str.mckSet;
    setVec[PB_RST] = str.rstSet;
    clrVec[PB_RST] = str.rstClr;
    pendNext = (pending & ~ackClear & ~clrVec) | setVec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= '0;
      irqReq   <= 1'b0;
      haltOut  <= 1'b0;
      resetReq <= 1'b0;
      tbEnable <= 1'b0;
    end else begin
      pending  <= pendNext;
      irqReq   <= |pendNext;
      resetReq <= str.sysReset;
      if (str.haltSet) haltOut <= 1'b1;
      if (str.tbOn)       tbEnable <= 1'b1;
      else if (str.tbOff) tbEnable <= 1'b0;
    end
  end

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    haltOut |=> haltOut); // R6
  AST_MCK_KEPT: assert property (@(posedge clk) disable iff (rst)
    (pending[PB_MCK] && !ackClear[PB_MCK]) |=> pending[PB_MCK]); // R4
  AST_IRQ_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    irqReq == (pending != '0)); // R5
  AST_RESET_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    resetReq |=> !resetReq); // R7
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pinctl_pkg::*;
#(
  parameter int PIN_W  = 8,
  parameter int PEND_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  pinIn,
  input  logic [PEND_W-1:0] ackClear,
  output logic [PEND_W-1:0] pending,
  output logic              irqReq,
  output logic              haltOut,
  output logic              resetReq,
  output logic              tbEnable
);
  logic [PIN_W-1:0] syncedPins;
  pin_strobe_t      strobes;

  pinctl_sync #(.W(PIN_W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .din(pinIn), .dout(syncedPins)
  );

  pinctl_ctrl #(.PIN_W(PIN_W)) u_ctrl (
    .clk(clk), .rst(rst), .synced(syncedPins), .str(strobes)
  );

  pinctl_dp #(.PEND_W(PEND_W)) u_dp (
    .clk(clk), .rst(rst), .str(strobes), .ackClear(ackClear),
    .pending(pending), .irqReq(irqReq), .haltOut(haltOut),
    .resetReq(resetReq), .tbEnable(tbEnable)
  );
endmodule

// File: tb/tb_pin_irq_ctrl.sv
module tb_pin_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  pinIn;
  logic [31:0] ackClear;
  logic [31:0] pending;
  logic        irqReq, haltOut, resetReq, tbEnable;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_ctrl dut (
    .clk(clk), .rst(rst), .pinIn(pinIn), .ackClear(ackClear),
    .pending(pending), .irqReq(irqReq), .haltOut(haltOut),
    .resetReq(resetReq), .tbEnable(tbEnable)
  );

  // behavioural reference model
  logic [7:0]  q1, q2, syn, mLast;
  logic [31:0] mPend;
  logic        mHalt, mRreq, mTb;

  always @(posedge clk) begin
    if (rst) begin
      q1 = 0; q2 = 0; mLast = 0; mPend = 0; mHalt = 0; mRreq = 0; mTb = 0;
    end else begin
      syn = q2; q2 = q1; q1 = pinIn;
      mPend = mPend & ~ackClear;
      mRreq = 1'b0;
      for (int k = 0; k < 7; k++) begin
        if (syn[k] != mLast[k]) begin
          case (k)
            0: mPend[0] = syn[k];
            1: mPend[1] = syn[k];
            2: if (!syn[k]) mPend[2] = 1'b1;
            3: if (syn[k]) mHalt = 1'b1;
            4: if (syn[k]) mRreq = 1'b1;
            5: mPend[3] = syn[k];
            default: mTb = syn[k];
          endcase
        end
      end
      mLast = syn & 8'h7f;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(pending === mPend, "R3 model pending", pending, mPend);
      check(irqReq === (mPend != 0), "R5 model irqReq", {31'd0, irqReq}, {31'd0, mPend != 0});
      check(haltOut === mHalt, "R6 model halt", {31'd0, haltOut}, {31'd0, mHalt});
      check(resetReq === mRreq, "R7 model resetReq", {31'd0, resetReq}, {31'd0, mRreq});
      check(tbEnable === mTb, "R9 model tbEnable", {31'd0, tbEnable}, {31'd0, mTb});
    end
  end

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ackPulse(input logic [31:0] m);
    ackClear = m;
    @(negedge clk);
    ackClear = '0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rst = 1'b1; pinIn = '0; ackClear = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check(pending == 0 && !irqReq && !haltOut && !resetReq && !tbEnable,
          "R12 reset state", pending, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2 latency, R3 external interrupt
    pinIn[0] = 1'b1;
    repeat (2) @(posedge clk); @(negedge clk);
    check(pending == 0, "R2 not yet after two edges", pending, 0);
    @(posedge clk); @(negedge clk);
    check(pending == 32'h1, "R3 ext sets bit0 after three edges", pending, 32'h1);
    check(irqReq == 1'b1, "R5 irqReq with pending", {31'd0, irqReq}, 1);

    // R10 ack clears, R1 held level no retrigger
    ackPulse(32'h1);
    check(pending == 0, "R10 ack clears bit0", pending, 0);
    repeat (4) @(negedge clk);
    check(pending == 0 && !irqReq, "R1 held level no retrigger", pending, 0);

    pinIn[0] = 1'b0; settle();
    pinIn[1] = 1'b1; settle();
    check(pending == 32'h2, "R3 smi sets bit1", pending, 32'h2);
    pinIn[1] = 1'b0; settle();
    check(pending == 0 && !irqReq, "R5 irqReq drops when vector empty", pending, 0);

    // R4 machine check
    pinIn[2] = 1'b1; settle();
    check(pending == 0, "R4 rise sets nothing", pending, 0);
    pinIn[2] = 1'b0; settle();
    check(pending == 32'h4, "R4 fall sets bit2", pending, 32'h4);
    pinIn[2] = 1'b1; settle();
    check(pending == 32'h4, "R4 rise does not clear", pending, 32'h4);
    ackPulse(32'h4);
    check(pending == 0, "R10 ack clears bit2", pending, 0);

    // R8 soft reset
    pinIn[5] = 1'b1; settle();
    check(pending == 32'h8, "R8 soft reset sets bit3", pending, 32'h8);
    pinIn[5] = 1'b0; settle();
    check(pending == 0, "R8 soft reset clears bit3", pending, 0);

    // R9 time base
    pinIn[6] = 1'b1; settle();
    check(tbEnable == 1'b1 && pending == 0, "R9 tb on, pending untouched", pending, 0);
    pinIn[6] = 1'b0; settle();
    check(tbEnable == 1'b0 && pending == 0, "R9 tb off", {31'd0, tbEnable}, 0);

    // R7 hard reset pulse
    pinIn[4] = 1'b1; settle();
    check(resetReq == 1'b1, "R7 reset request raised", {31'd0, resetReq}, 1);
    @(negedge clk);
    check(resetReq == 1'b0, "R7 reset request one cycle", {31'd0, resetReq}, 0);
    pinIn[4] = 1'b0; settle();
    check(resetReq == 1'b0, "R7 fall does nothing", {31'd0, resetReq}, 0);

    // R11 spare pin
    pinIn[7] = 1'b1; settle();
    check(pending == 0 && !irqReq && !haltOut && !resetReq && !tbEnable,
          "R11 spare pin rise ignored", pending, 0);
    pinIn[7] = 1'b0; settle();
    check(pending == 0 && !haltOut && !tbEnable, "R11 spare pin fall ignored", pending, 0);

    // R10 set wins over ack in the same edge
    pinIn[0] = 1'b1;
    @(negedge clk); @(negedge clk);
    ackClear = 32'h1;
    @(negedge clk);
    ackClear = '0;
    check(pending == 32'h1, "R10 set wins over ack", pending, 32'h1);
    pinIn[0] = 1'b0; settle();

    // R6 checkstop
    pinIn[3] = 1'b1; settle();
    check(haltOut == 1'b1, "R6 checkstop halts", {31'd0, haltOut}, 1);
    pinIn[3] = 1'b0; settle();
    repeat (3) @(negedge clk);
    check(haltOut == 1'b1, "R6 halt sticky after release", {31'd0, haltOut}, 1);

    // R12 reset mid-run
    pinIn[5] = 1'b1; pinIn[6] = 1'b1; settle();
    rst = 1'b1; @(negedge clk);
    check(pending == 0 && !irqReq && !haltOut && !tbEnable, "R12 reset clears all", pending, 0);
    rst = 1'b0; pinIn = '0;
    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule